// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This unit sits at the edge of a DRAM controller and gathers performance statistics from the per-cycle event strobes that the controller exposes. It holds four 32-bit counters. Each counter has its own 8-bit select register that picks the event it counts. Counter 0 is the time base: it counts clock cycles whatever its select register holds. When counter 0 wraps, every counter freezes and an interrupt is raised. The freeze and the interrupt stay in place until software clears them.

Two event codes count AXI read or write address beats whose ID passes a masked-match filter. All counters share this one filter. An enhanced mode makes those two events add the byte count of each burst instead of one per burst.

Software uses a small word-addressed register port to configure the unit, preload counters and read them back. A control register starts and stops counting, zeroes the counters and acknowledges the interrupt.

Top module: `memctl_perf_unit`

## Requirements
- R1: Four 32-bit counters are read at addresses 0x8 to 0xB (counter n at 0x8+n). A write to one of these addresses preloads that counter with the write data.
- R2: Counters 1 to 3 each take an 8-bit event code from their select register (counter n at address 0x1+n). A code below 32 adds one on every counting cycle in which `evt_i[code]` is high. Codes that are not defined count nothing.
- R3: Counter 0 adds one on every cycle in which counting is enabled and not frozen, whatever its select register at 0x1 holds.
- R4: When counter 0 wraps from 0xFFFFFFFF to 0, the freeze flag and `irq_o` are set on the next cycle. While frozen, no counter changes except by preload or clear.
- R5: Counters 1 to 3 wrap from 0xFFFFFFFF to 0 and keep counting, and `irq_o` is not affected.
- R6: Event code 0x41 counts accepted read address beats and code 0x42 counts accepted write address beats, but only when `(id & mask) == (filter_id & mask)`. The filter register at 0x5 holds filter_id in bits [15:0] and mask in bits [31:16]. A mask bit of 1 means the ID bit is compared.
- R7: When control bit 3 (enhanced) is set, codes 0x41 and 0x42 add `(len+1) << size` for each matching beat instead of 1.
- R8: Control bit 0 (enable) at address 0x0 gates all counting. While it is 0, the counters hold their values.
- R9: Writing control with bit 1 set zeroes all four counters on that cycle, and this takes priority over counting.
- R10: Writing control with bit 2 set clears the freeze flag and `irq_o`. Control reads return enable in bit 0, enhanced in bit 3 and the freeze flag in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Per-cycle event strobes |
| rd_valid_i | input | 1 | Read address beat accepted |
| rd_id_i | input | 16 | Read transaction ID |
| rd_len_i | input | 8 | Read burst length minus one |
| rd_size_i | input | 3 | Read beat size, log2 bytes |
| wr_valid_i | input | 1 | Write address beat accepted |
| wr_id_i | input | 16 | Write transaction ID |
| wr_len_i | input | 8 | Write burst length minus one |
| wr_size_i | input | 3 | Write beat size, log2 bytes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Counter 0 expiry interrupt, sticky |

## Verification
The assertions check on every cycle that counter 0 steps by one while enabled, that its wrap raises the interrupt, and that a frozen or disabled counter holds still. They also check that a clear zeroes the counters and that a wrap of an event counter leaves the interrupt low. Only the bench scenarios can show the filter's masked compare on chosen IDs, the byte sums in enhanced mode, the lack of effect of counter 0's select and of undefined codes, and the resumption of counting after the interrupt is acknowledged.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_SEL0 = 4'h1;
  localparam logic [3:0] ADDR_FILT = 4'h5;
  localparam logic [3:0] ADDR_CNT0 = 4'h8;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_CLR_CNT = 1;
  localparam int CTRL_CLR_IRQ = 2;
  localparam int CTRL_ENH     = 3;
  localparam int CTRL_LOCK    = 4;

  localparam logic [7:0] EVT_RD_FILT = 8'h41;
  localparam logic [7:0] EVT_WR_FILT = 8'h42;
endpackage

// File: rtl/perf_id_filter.sv
module perf_id_filter #(
  parameter int ID_W   = 16,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 32
) (
  input  logic              rd_valid_i,
  input  logic [ID_W-1:0]   rd_id_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  input  logic [SIZE_W-1:0] rd_size_i,
  input  logic              wr_valid_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [ID_W-1:0]   filt_id_i,
  input  logic [ID_W-1:0]   filt_mask_i,
  output logic              rd_hit_o,
  output logic              wr_hit_o,
  output logic [CNT_W-1:0]  rd_bytes_o,
  output logic [CNT_W-1:0]  wr_bytes_o
);
  logic [CNT_W-1:0] rd_beats, wr_beats;

  assign rd_hit_o = rd_valid_i && ((rd_id_i & filt_mask_i) == (filt_id_i & filt_mask_i));
  assign wr_hit_o = wr_valid_i && ((wr_id_i & filt_mask_i) == (filt_id_i & filt_mask_i));

  assign rd_beats   = CNT_W'(rd_len_i) + CNT_W'(1);
  assign wr_beats   = CNT_W'(wr_len_i) + CNT_W'(1);
  assign rd_bytes_o = rd_beats << rd_size_i;
  assign wr_bytes_o = wr_beats << wr_size_i;
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel import perf_pkg::*; #(
  parameter int NUM_EVT = 32,
  parameter int CNT_W   = 32
) (
  input  logic [7:0]         code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rd_hit_i,
  input  logic               wr_hit_i,
  input  logic [CNT_W-1:0]   rd_bytes_i,
  input  logic [CNT_W-1:0]   wr_bytes_i,
  input  logic               enh_i,
  output logic               hit_o,
  output logic [CNT_W-1:0]   amt_o
);
  localparam int EW = $clog2(NUM_EVT);

  always_comb begin
    hit_o = 1'b0;
    amt_o = CNT_W'(1);
    if (code_i == EVT_RD_FILT) begin
      hit_o = rd_hit_i;
      if (enh_i) amt_o = rd_bytes_i;
    end else if (code_i == EVT_WR_FILT) begin
      hit_o = wr_hit_i;
      if (enh_i) amt_o = wr_bytes_i;
    end else if (int'(code_i) < NUM_EVT) begin
      hit_o = evt_i[code_i[EW-1:0]];
    end
  end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_en_i,
  input  logic [CNT_W-1:0] inc_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, sum;
  logic             carry;

  assign {carry, sum} = {1'b0, cnt_q} + {1'b0, inc_val_i};
  assign wrap_o = inc_en_i && carry && !clr_i && !load_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (inc_en_i) cnt_q <= sum;
  end

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_en_i && !clr_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/memctl_perf_unit.sv
module memctl_perf_unit import perf_pkg::*; #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 32,
  parameter int ID_W    = 16,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rd_valid_i,
  input  logic [ID_W-1:0]    rd_id_i,
  input  logic [LEN_W-1:0]   rd_len_i,
  input  logic [SIZE_W-1:0]  rd_size_i,
  input  logic               wr_valid_i,
  input  logic [ID_W-1:0]    wr_id_i,
  input  logic [LEN_W-1:0]   wr_len_i,
  input  logic [SIZE_W-1:0]  wr_size_i,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o
);
  logic             en_q, enh_q, lock_q;
  logic [7:0]       sel_q  [NUM_CNT];
  logic [ID_W-1:0]  filt_id_q, filt_mask_q;
  logic [CNT_W-1:0] cnt    [NUM_CNT];
  logic             wrap   [NUM_CNT];
  logic             ld     [NUM_CNT];

  logic wr_ctrl, cnt_clr, irq_clr, count_en;
  logic rd_hit, wr_hit;
  logic [CNT_W-1:0] rd_bytes, wr_bytes;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign cnt_clr  = wr_ctrl && reg_wdata_i[CTRL_CLR_CNT];
  assign irq_clr  = wr_ctrl && reg_wdata_i[CTRL_CLR_IRQ];
  assign count_en = en_q && !lock_q;
  assign irq_o    = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      enh_q       <= 1'b0;
      filt_id_q   <= '0;
      filt_mask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_CTRL) begin
        en_q  <= reg_wdata_i[CTRL_EN];
        enh_q <= reg_wdata_i[CTRL_ENH];
      end
      if (reg_addr_i == ADDR_FILT) begin
        filt_id_q   <= reg_wdata_i[ID_W-1:0];
        filt_mask_q <= reg_wdata_i[2*ID_W-1:ID_W];
      end
    end
  end

  // expiry wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lock_q <= 1'b0;
    else if (wrap[0]) lock_q <= 1'b1;
    else if (irq_clr) lock_q <= 1'b0;
  end

  perf_id_filter #(
    .ID_W(ID_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_filt (
    .rd_valid_i (rd_valid_i), .rd_id_i (rd_id_i), .rd_len_i (rd_len_i), .rd_size_i (rd_size_i),
    .wr_valid_i (wr_valid_i), .wr_id_i (wr_id_i), .wr_len_i (wr_len_i), .wr_size_i (wr_size_i),
    .filt_id_i  (filt_id_q),  .filt_mask_i (filt_mask_q),
    .rd_hit_o   (rd_hit),     .wr_hit_o (wr_hit),
    .rd_bytes_o (rd_bytes),   .wr_bytes_o (wr_bytes)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic             inc_en;
    logic [CNT_W-1:0] inc_val;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[i] <= '0;
      else if (reg_we_i && reg_addr_i == ADDR_SEL0 + 4'(i)) sel_q[i] <= reg_wdata_i[7:0];
    end

    assign ld[i] = reg_we_i && (reg_addr_i == ADDR_CNT0 + 4'(i));

    if (i == 0) begin : g_time
      assign inc_en  = count_en;
      assign inc_val = CNT_W'(1);
    end else begin : g_evt
      logic hit;
      perf_evt_sel #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_sel (
        .code_i     (sel_q[i]),
        .evt_i      (evt_i),
        .rd_hit_i   (rd_hit),
        .wr_hit_i   (wr_hit),
        .rd_bytes_i (rd_bytes),
        .wr_bytes_i (wr_bytes),
        .enh_i      (enh_q),
        .hit_o      (hit),
        .amt_o      (inc_val)
      );
      assign inc_en = count_en && hit;
    end

    perf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (cnt_clr),
      .load_i     (ld[i]),
      .load_val_i (reg_wdata_i[CNT_W-1:0]),
      .inc_en_i   (inc_en),
      .inc_val_i  (inc_val),
      .cnt_o      (cnt[i]),
      .wrap_o     (wrap[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CTRL) begin
      reg_rdata_o[CTRL_EN]   = en_q;
      reg_rdata_o[CTRL_ENH]  = enh_q;
      reg_rdata_o[CTRL_LOCK] = lock_q;
    end else if (reg_addr_i == ADDR_FILT) begin
      reg_rdata_o[2*ID_W-1:0] = {filt_mask_q, filt_id_q};
    end
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr_i == ADDR_SEL0 + 4'(k)) reg_rdata_o[7:0] = sel_q[k];
      if (reg_addr_i == ADDR_CNT0 + 4'(k)) reg_rdata_o[CNT_W-1:0] = cnt[k];
    end
  end

  assert_c0_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && !cnt_clr && !ld[0]) |=> cnt[0] == $past(cnt[0]) + CNT_W'(1));

  assert_irq_on_expiry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[0] |=> irq_o);

  assert_lock_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !cnt_clr && !ld[1]) |=> $stable(cnt[1]));

  assert_silent_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap[1] && !wrap[0] && !lock_q) |=> !irq_o);

  assert_cnt_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> (cnt[0] == '0 && cnt[NUM_CNT-1] == '0));
endmodule

// File: tb/sim_memctl_perf_unit.sv
module sim_memctl_perf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        rd_v = 1'b0, wr_v = 1'b0;
  logic [15:0] rd_id = '0, wr_id = '0;
  logic [7:0]  rd_len = '0, wr_len = '0;
  logic [2:0]  rd_sz = '0, wr_sz = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  memctl_perf_unit u0 (
    .clk_i (clk), .rst_ni (rst_n), .evt_i (evt),
    .rd_valid_i (rd_v), .rd_id_i (rd_id), .rd_len_i (rd_len), .rd_size_i (rd_sz),
    .wr_valid_i (wr_v), .wr_id_i (wr_id), .wr_len_i (wr_len), .wr_size_i (wr_sz),
    .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rreg(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_evt(input int b);
    @(negedge clk); evt[b] = 1'b1;
    @(negedge clk); evt[b] = 1'b0;
  endtask

  task automatic pulse_axi(input logic r, input logic [15:0] rid, input logic [7:0] rl, input logic [2:0] rs,
                           input logic w, input logic [15:0] wid, input logic [7:0] wl, input logic [2:0] ws);
    @(negedge clk);
    rd_v = r; rd_id = rid; rd_len = rl; rd_sz = rs;
    wr_v = w; wr_id = wid; wr_len = wl; wr_sz = ws;
    @(negedge clk);
    rd_v = 1'b0; wr_v = 1'b0;
  endtask

  task automatic t_reset;
    chk_reg("R1 reset cnt0", 4'h8, 32'h0);
    chk_reg("R1 reset cnt3", 4'hB, 32'h0);
    chk_reg("R10 reset ctrl", 4'h0, 32'h0);
    chk("R4 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_basic;
    wreg(4'h1, 32'h05);   // R3: select of counter 0 has no effect
    wreg(4'h2, 32'h03);
    wreg(4'h3, 32'h04);
    wreg(4'h4, 32'h7F);   // R2: undefined code
    @(negedge clk); evt[3] = 1'b1; evt[31] = 1'b1;
    wreg(4'h0, 32'h1);
    repeat (10) @(posedge clk);
    wreg(4'h0, 32'h0);
    evt = '0;
    chk_reg("R3 cycle count", 4'h8, 32'd11);
    chk_reg("R2 evt3 count", 4'h9, 32'd11);
    chk_reg("R2 idle evt count", 4'hA, 32'd0);
    chk_reg("R2 undefined code", 4'hB, 32'd0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk_reg("R8 disabled hold", 4'h8, 32'd11);
  endtask

  task automatic t_clear;
    wreg(4'h0, 32'h2);
    chk_reg("R9 clear cnt0", 4'h8, 32'd0);
    chk_reg("R9 clear cnt1", 4'h9, 32'd0);
  endtask

  task automatic t_filter;
    wreg(4'h0, 32'h2);
    wreg(4'h2, 32'h41);
    wreg(4'h3, 32'h42);
    wreg(4'h5, 32'h00FF_0012);
    chk_reg("R6 filter readback", 4'h5, 32'h00FF_0012);
    wreg(4'h0, 32'h1);
    pulse_axi(1, 16'h0312, 8'd0, 3'd0, 0, 16'h0, 8'd0, 3'd0);
    pulse_axi(1, 16'h0013, 8'd0, 3'd0, 0, 16'h0, 8'd0, 3'd0);
    pulse_axi(0, 16'h0, 8'd0, 3'd0, 1, 16'hAB12, 8'd0, 3'd0);
    pulse_axi(0, 16'h0, 8'd0, 3'd0, 1, 16'h0000, 8'd0, 3'd0);
    pulse_axi(1, 16'h0012, 8'd5, 3'd2, 1, 16'h0012, 8'd5, 3'd2);
    wreg(4'h0, 32'h0);
    chk_reg("R6 filtered reads", 4'h9, 32'd2);
    chk_reg("R6 filtered writes", 4'hA, 32'd2);
  endtask

  task automatic t_enh;
    wreg(4'h0, 32'h2);
    wreg(4'h0, 32'h9);
    chk_reg("R10 ctrl readback", 4'h0, 32'h9);
    pulse_axi(1, 16'h0012, 8'd3, 3'd2, 1, 16'h0012, 8'd0, 3'd0);
    pulse_axi(0, 16'h0, 8'd0, 3'd0, 1, 16'h1112, 8'd7, 3'd3);
    pulse_axi(1, 16'h0099, 8'd3, 3'd2, 0, 16'h0, 8'd0, 3'd0);
    wreg(4'h0, 32'h0);
    chk_reg("R7 read bytes", 4'h9, 32'd16);
    chk_reg("R7 write bytes", 4'hA, 32'd65);
  endtask

  task automatic t_wrap_silent;
    wreg(4'h0, 32'h2);
    wreg(4'h2, 32'h03);
    wreg(4'h9, 32'hFFFF_FFFF);
    chk_reg("R1 preload", 4'h9, 32'hFFFF_FFFF);
    wreg(4'h0, 32'h1);
    pulse_evt(3);
    pulse_evt(3);
    wreg(4'h0, 32'h0);
    chk_reg("R5 wrapped value", 4'h9, 32'd1);
    chk("R5 no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_expiry;
    wreg(4'h0, 32'h2);
    wreg(4'h8, 32'hFFFF_FFFD);
    wreg(4'h0, 32'h1);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R4 irq raised", {31'b0, irq}, 32'h1);
    chk_reg("R4 cnt0 frozen", 4'h8, 32'd0);
    chk_reg("R10 lock flag", 4'h0, 32'h11);
    pulse_evt(3);
    chk_reg("R4 cnt1 frozen", 4'h9, 32'd0);
  endtask

  task automatic t_irq_clear;
    wreg(4'h0, 32'h5);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk_reg("R10 counting resumes", 4'h8, 32'd5);
    wreg(4'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_filter();
    t_enh();
    t_wrap_silent();
    t_expiry();
    t_irq_clear();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule